// File: doc/BRIEF.md
# Endpoint Loopback Test Command Engine

This block is a small command engine that sits behind a bus endpoint and lets host software exercise that endpoint. The host programs it through a register-slave port: word-indexed writes and a combinational read. The engine reaches host memory through a word-wide memory-master port that uses a request/acknowledge handshake. The host loads a source address, a destination address and a byte count, selects an interrupt style and vector, and then writes one command bit. The engine either moves data or raises an interrupt request. It reports the outcome through sticky status bits that the host clears by writing ones.

There are three transfer commands. A read sums words taken from a host buffer. A write fills a host buffer with an incrementing pattern. A copy moves a buffer one word at a time: each word is read and then written before the next word is read. Before any memory access, every address the command uses is checked for alignment, for a nonzero whole-word size, and for lying inside a configured host window. A command that fails the check makes no memory access. When a command finishes, the engine issues a one-cycle interrupt request that carries the programmed style and vector, but only if that vector is legal for the style. A scratch register gives the host a simple way to prove that the register window works.

Top module: `eptest_engine`

## Requirements
- R1: Register word indices are: 0 scratch, 1 command, 2 status, 3 source address, 4 destination address, 5 byte count, 6 checksum (read-only), 7 interrupt style, 8 interrupt vector. After reset every one of them reads 0. The scratch register returns exactly the last 32-bit value written to it.
- R2: Command bits are: 0 legacy interrupt, 1 MSI, 2 MSI-X, 3 read, 4 write, 5 copy. A written command is accepted on the next clock, and from then on the command index reads 0.
- R3: A command write that arrives while a command is pending or running has no effect: it makes no memory access, sets no status bit and raises no interrupt.
- R4: A read fetches count/4 words, starting at the source address and rising by 4. It leaves their 32-bit wrapping sum in the checksum register and sets status bit 0.
- R5: A write stores the value k at destination + 4k for k = 0 .. count/4-1. It leaves the sum of those values in the checksum register and sets status bit 2.
- R6: A copy moves count/4 words from source to destination. It alternates one read and one write per word. The checksum holds the sum of the moved words, and status bit 4 is set.
- R7: An address is invalid if the count is zero or not a multiple of 4, if the address is not 4-byte aligned, or if any part of [address, address+count) lies outside the host window (default 0x1000 to 0x1FFF). An invalid source sets status bit 7 and an invalid destination sets bit 8. The command's fail bit is set (bit 1 read, bit 3 write, bit 5 copy). No memory request is made and the checksum is left unchanged.
- R8: Interrupt styles are encoded 0 legacy, 1 MSI and 2 MSI-X. The vector must be 0 for legacy, 1..32 for MSI and 1..2048 for MSI-X. Any other pair, including style 3, raises no interrupt and leaves status bit 6 clear.
- R9: On completion, whether the command passed or failed, a legal interrupt setting produces a single-cycle irq_pulse with irq_kind/irq_num equal to the programmed style and vector. Status bit 6 reads 1 in that same cycle.
- R10: Command bits 0, 1 and 2 each raise an interrupt at once, using the style and vector registers, with no memory access.
- R11: Writing the status index clears exactly the bits written as 1 and leaves the other status bits unchanged.
- R12: When several command bits are written together, only the lowest-numbered one is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_kind | output | 2 | Interrupt style carried with irq_pulse |
| irq_num | output | NUM_W | Interrupt vector carried with irq_pulse |

## Verification
If the sequencer's word counter or address registers were corrupted, the error would appear at the memory port during the command itself. The bench would see too many or too few requests, or an address that does not advance by 4. The checksum would then read back wrong once the command completes. If the address-check or interrupt-gate state were wrong, the error would appear at the completion cycle. The status word would show the wrong pass/fail/invalid combination, a memory request would appear on a command that should have been refused, or irq_pulse would fire or fail to fire in the cycle where status bit 6 changes. The table of commands therefore drives each command kind and each refusal reason. Directed cases then cover collisions with a running command, command priority, and clearing of status bits.

// File: rtl/eptest_pkg.sv
package eptest_pkg;

   localparam int IDX_W  = 4;
   localparam int CMD_W  = 6;
   localparam int ST_W   = 9;
   localparam int TYPE_W = 2;

   localparam logic [IDX_W-1:0] IX_SCRATCH = 4'd0;
   localparam logic [IDX_W-1:0] IX_CMD     = 4'd1;
   localparam logic [IDX_W-1:0] IX_STATUS  = 4'd2;
   localparam logic [IDX_W-1:0] IX_SRC     = 4'd3;
   localparam logic [IDX_W-1:0] IX_DST     = 4'd4;
   localparam logic [IDX_W-1:0] IX_COUNT   = 4'd5;
   localparam logic [IDX_W-1:0] IX_CSUM    = 4'd6;
   localparam logic [IDX_W-1:0] IX_ITYPE   = 4'd7;
   localparam logic [IDX_W-1:0] IX_INUM    = 4'd8;

   localparam int CB_LEG  = 0;
   localparam int CB_MSI  = 1;
   localparam int CB_MSIX = 2;
   localparam int CB_RD   = 3;
   localparam int CB_WR   = 4;
   localparam int CB_CP   = 5;

   localparam int SB_RD_OK   = 0;
   localparam int SB_RD_FAIL = 1;
   localparam int SB_WR_OK   = 2;
   localparam int SB_WR_FAIL = 3;
   localparam int SB_CP_OK   = 4;
   localparam int SB_CP_FAIL = 5;
   localparam int SB_IRQ     = 6;
   localparam int SB_SRC_BAD = 7;
   localparam int SB_DST_BAD = 8;

   localparam logic [TYPE_W-1:0] IT_LEGACY = 2'd0;
   localparam logic [TYPE_W-1:0] IT_MSI    = 2'd1;
   localparam logic [TYPE_W-1:0] IT_MSIX   = 2'd2;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_IRQ,
      OP_READ,
      OP_WRITE,
      OP_COPY
   } op_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_RD,
      S_WR
   } seq_state_e;

endpackage

// File: rtl/eptest_addr_check.sv
module eptest_addr_check #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 'h1000,
   parameter logic [ADDR_W-1:0] WIN_BYTES = 'h1000
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] count_i,
   output logic              ok_o
);
   localparam logic [ADDR_W:0] LO_LIM = {1'b0, WIN_BASE};
   localparam logic [ADDR_W:0] HI_LIM = {1'b0, WIN_BASE} + {1'b0, WIN_BYTES};

   logic [ADDR_W:0] first_b;
   logic [ADDR_W:0] end_b;
   logic            shape_ok;

   always_comb begin
      first_b  = {1'b0, base_i};
      end_b    = first_b + {1'b0, count_i};
      shape_ok = (base_i[1:0] == 2'b00) && (count_i[1:0] == 2'b00) && (count_i != '0);
      ok_o     = shape_ok && (first_b >= LO_LIM) && (end_b <= HI_LIM);
   end
endmodule

// File: rtl/eptest_irq_gate.sv
module eptest_irq_gate #(
   parameter int NUM_W    = 12,
   parameter int MSI_MAX  = 32,
   parameter int MSIX_MAX = 2048
) (
   input  logic [eptest_pkg::TYPE_W-1:0] type_i,
   input  logic [NUM_W-1:0]              num_i,
   output logic                          ok_o
);
   import eptest_pkg::*;

   localparam logic [NUM_W-1:0] MSI_LIM  = NUM_W'(MSI_MAX);
   localparam logic [NUM_W-1:0] MSIX_LIM = NUM_W'(MSIX_MAX);

   logic nonzero;

   always_comb begin
      nonzero = (num_i != '0);
      unique case (type_i)
         IT_LEGACY: ok_o = !nonzero;
         IT_MSI:    ok_o = nonzero && (num_i <= MSI_LIM);
         IT_MSIX:   ok_o = nonzero && (num_i <= MSIX_LIM);
         default:   ok_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/eptest_regfile.sv
module eptest_regfile #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int NUM_W  = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [eptest_pkg::IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0]             wdata_i,
   output logic [DATA_W-1:0]             rdata_o,
   input  logic                          busy_i,
   input  logic                          accept_i,
   input  logic [eptest_pkg::ST_W-1:0]   st_set_i,
   input  logic [DATA_W-1:0]             csum_i,
   output logic [eptest_pkg::CMD_W-1:0]  cmd_o,
   output logic [ADDR_W-1:0]             src_o,
   output logic [ADDR_W-1:0]             dst_o,
   output logic [ADDR_W-1:0]             count_o,
   output logic [eptest_pkg::TYPE_W-1:0] itype_o,
   output logic [NUM_W-1:0]              inum_o
);
   import eptest_pkg::*;

   logic [DATA_W-1:0] scratch_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [ST_W-1:0]   status_q;
   logic [ADDR_W-1:0] src_q;
   logic [ADDR_W-1:0] dst_q;
   logic [ADDR_W-1:0] count_q;
   logic [TYPE_W-1:0] itype_q;
   logic [NUM_W-1:0]  inum_q;
   logic [ST_W-1:0]   clr_mask;
   logic              cmd_take;

   always_comb begin
      clr_mask = (we_i && idx_i == IX_STATUS) ? wdata_i[ST_W-1:0] : '0;
      cmd_take = we_i && (idx_i == IX_CMD) && !busy_i && (cmd_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scratch_q <= '0;
         cmd_q     <= '0;
         status_q  <= '0;
         src_q     <= '0;
         dst_q     <= '0;
         count_q   <= '0;
         itype_q   <= '0;
         inum_q    <= '0;
      end else begin
         status_q <= (status_q & ~clr_mask) | st_set_i;
         if (accept_i)
            cmd_q <= '0;
         else if (cmd_take)
            cmd_q <= wdata_i[CMD_W-1:0];
         if (we_i) begin
            unique case (idx_i)
               IX_SCRATCH: scratch_q <= wdata_i;
               IX_SRC:     src_q     <= ADDR_W'(wdata_i);
               IX_DST:     dst_q     <= ADDR_W'(wdata_i);
               IX_COUNT:   count_q   <= ADDR_W'(wdata_i);
               IX_ITYPE:   itype_q   <= wdata_i[TYPE_W-1:0];
               IX_INUM:    inum_q    <= wdata_i[NUM_W-1:0];
               default:    ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (idx_i)
         IX_SCRATCH: rdata_o = scratch_q;
         IX_CMD:     rdata_o = DATA_W'(cmd_q);
         IX_STATUS:  rdata_o = DATA_W'(status_q);
         IX_SRC:     rdata_o = DATA_W'(src_q);
         IX_DST:     rdata_o = DATA_W'(dst_q);
         IX_COUNT:   rdata_o = DATA_W'(count_q);
         IX_CSUM:    rdata_o = csum_i;
         IX_ITYPE:   rdata_o = DATA_W'(itype_q);
         IX_INUM:    rdata_o = DATA_W'(inum_q);
         default:    rdata_o = '0;
      endcase
   end

   assign cmd_o   = cmd_q;
   assign src_o   = src_q;
   assign dst_o   = dst_q;
   assign count_o = count_q;
   assign itype_o = itype_q;
   assign inum_o  = inum_q;
endmodule

// File: rtl/eptest_seq.sv
module eptest_seq #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int NUM_W     = 12,
   parameter bit COPY_SUMS = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [eptest_pkg::CMD_W-1:0]  cmd_i,
   input  logic [ADDR_W-1:0]             src_i,
   input  logic [ADDR_W-1:0]             dst_i,
   input  logic [ADDR_W-1:0]             count_i,
   input  logic                          src_ok_i,
   input  logic                          dst_ok_i,
   input  logic                          irq_ok_i,
   input  logic [eptest_pkg::TYPE_W-1:0] irq_type_i,
   input  logic [NUM_W-1:0]              irq_num_i,
   input  logic                          mem_ack_i,
   input  logic [DATA_W-1:0]             mem_rdata_i,
   output logic                          accept_o,
   output logic                          busy_o,
   output logic [eptest_pkg::ST_W-1:0]   st_set_o,
   output logic [DATA_W-1:0]             csum_o,
   output logic                          mem_req_o,
   output logic                          mem_we_o,
   output logic [ADDR_W-1:0]             mem_addr_o,
   output logic [DATA_W-1:0]             mem_wdata_o,
   output logic                          irq_pulse_o,
   output logic [eptest_pkg::TYPE_W-1:0] irq_kind_o,
   output logic [NUM_W-1:0]              irq_num_o
);
   import eptest_pkg::*;

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

   seq_state_e        state_q;
   op_e               op_q;
   op_e               req_op;
   logic [ADDR_W-1:0] cur_src_q;
   logic [ADDR_W-1:0] cur_dst_q;
   logic [ADDR_W-1:0] left_q;
   logic [DATA_W-1:0] pat_q;
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] csum_q;
   logic [DATA_W-1:0] copy_term;
   logic [DATA_W-1:0] rd_term;
   logic [DATA_W-1:0] wr_term;
   logic              finish;
   logic              last_word;
   logic              irq_q;
   logic [TYPE_W-1:0] kind_q;
   logic [NUM_W-1:0]  num_q;

   function automatic op_e pick_op(input logic [CMD_W-1:0] c);
      if (c[CB_LEG] || c[CB_MSI] || c[CB_MSIX]) return OP_IRQ;
      if (c[CB_RD]) return OP_READ;
      if (c[CB_WR]) return OP_WRITE;
      if (c[CB_CP]) return OP_COPY;
      return OP_NONE;
   endfunction

   generate
      if (COPY_SUMS) begin : g_copy_sum
         assign copy_term = mem_rdata_i;
      end else begin : g_copy_nosum
         assign copy_term = '0;
      end
   endgenerate

   always_comb begin
      req_op    = pick_op(cmd_i);
      accept_o  = (state_q == S_IDLE) && (cmd_i != '0);
      last_word = (left_q == ONE);
      rd_term   = (op_q == OP_READ) ? mem_rdata_i : copy_term;
      wr_term   = (op_q == OP_WRITE) ? pat_q : '0;
      finish    = 1'b0;
      st_set_o  = '0;
      if (accept_o) begin
         unique case (req_op)
            OP_IRQ: finish = 1'b1;
            OP_READ: if (!src_ok_i) begin
               finish = 1'b1;
               st_set_o[SB_RD_FAIL] = 1'b1;
               st_set_o[SB_SRC_BAD] = 1'b1;
            end
            OP_WRITE: if (!dst_ok_i) begin
               finish = 1'b1;
               st_set_o[SB_WR_FAIL] = 1'b1;
               st_set_o[SB_DST_BAD] = 1'b1;
            end
            OP_COPY: if (!(src_ok_i && dst_ok_i)) begin
               finish = 1'b1;
               st_set_o[SB_CP_FAIL] = 1'b1;
               st_set_o[SB_SRC_BAD] = !src_ok_i;
               st_set_o[SB_DST_BAD] = !dst_ok_i;
            end
            default: ;
         endcase
      end
      if (state_q == S_RD && mem_ack_i && op_q == OP_READ && last_word) begin
         finish = 1'b1;
         st_set_o[SB_RD_OK] = 1'b1;
      end
      if (state_q == S_WR && mem_ack_i && last_word) begin
         finish = 1'b1;
         st_set_o[SB_WR_OK] = (op_q == OP_WRITE);
         st_set_o[SB_CP_OK] = (op_q == OP_COPY);
      end
      if (finish && irq_ok_i)
         st_set_o[SB_IRQ] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         op_q      <= OP_NONE;
         cur_src_q <= '0;
         cur_dst_q <= '0;
         left_q    <= '0;
         pat_q     <= '0;
         hold_q    <= '0;
         csum_q    <= '0;
         irq_q     <= 1'b0;
         kind_q    <= '0;
         num_q     <= '0;
      end else begin
         irq_q <= finish && irq_ok_i;
         if (finish) begin
            kind_q <= irq_type_i;
            num_q  <= irq_num_i;
         end
         unique case (state_q)
            S_IDLE: if (accept_o && !finish) begin
               op_q      <= req_op;
               cur_src_q <= src_i;
               cur_dst_q <= dst_i;
               left_q    <= count_i >> 2;
               pat_q     <= '0;
               csum_q    <= '0;
               state_q   <= (req_op == OP_WRITE) ? S_WR : S_RD;
            end
            S_RD: if (mem_ack_i) begin
               csum_q    <= csum_q + rd_term;
               hold_q    <= mem_rdata_i;
               cur_src_q <= cur_src_q + STEP;
               if (op_q == OP_READ) begin
                  left_q <= left_q - ONE;
                  if (last_word) state_q <= S_IDLE;
               end else begin
                  state_q <= S_WR;
               end
            end
            S_WR: if (mem_ack_i) begin
               csum_q    <= csum_q + wr_term;
               cur_dst_q <= cur_dst_q + STEP;
               pat_q     <= pat_q + DATA_W'(1);
               left_q    <= left_q - ONE;
               if (last_word)
                  state_q <= S_IDLE;
               else if (op_q == OP_COPY)
                  state_q <= S_RD;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      busy_o      = (state_q != S_IDLE);
      mem_req_o   = (state_q == S_RD) || (state_q == S_WR);
      mem_we_o    = (state_q == S_WR);
      mem_addr_o  = (state_q == S_WR) ? cur_dst_q : cur_src_q;
      mem_wdata_o = (op_q == OP_COPY) ? hold_q : pat_q;
   end

   assign csum_o      = csum_q;
   assign irq_pulse_o = irq_q;
   assign irq_kind_o  = kind_q;
   assign irq_num_o   = num_q;
endmodule

// File: rtl/eptest_engine.sv
module eptest_engine #(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                NUM_W     = 12,
   parameter int                MSI_MAX   = 32,
   parameter int                MSIX_MAX  = 2048,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 'h1000,
   parameter logic [ADDR_W-1:0] WIN_BYTES = 'h1000,
   parameter bit                COPY_SUMS = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_we,
   input  logic [eptest_pkg::IDX_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   output logic                          mem_req,
   output logic                          mem_we,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [DATA_W-1:0]             mem_wdata,
   input  logic [DATA_W-1:0]             mem_rdata,
   input  logic                          mem_ack,
   output logic                          irq_pulse,
   output logic [eptest_pkg::TYPE_W-1:0] irq_kind,
   output logic [NUM_W-1:0]              irq_num
);
   import eptest_pkg::*;

   localparam int CHK_N = 2;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("eptest_engine: DATA_W must be 32");
      end
      if (ADDR_W > DATA_W || ADDR_W < 8) begin : g_bad_addr
         $error("eptest_engine: ADDR_W must lie in 8..DATA_W");
      end
      if (WIN_BASE[1:0] != 2'b00 || WIN_BYTES[1:0] != 2'b00 || WIN_BYTES == '0) begin : g_bad_win
         $error("eptest_engine: host window must be word aligned and nonempty");
      end
      if (MSI_MAX < 1 || MSIX_MAX < MSI_MAX || MSIX_MAX >= (1 << NUM_W)) begin : g_bad_num
         $error("eptest_engine: NUM_W too narrow for interrupt vector limits");
      end
   endgenerate

   logic [CMD_W-1:0]  cmd;
   logic [ADDR_W-1:0] src;
   logic [ADDR_W-1:0] dst;
   logic [ADDR_W-1:0] count;
   logic [TYPE_W-1:0] itype;
   logic [NUM_W-1:0]  inum;
   logic [ST_W-1:0]   st_set;
   logic [DATA_W-1:0] csum;
   logic              busy;
   logic              accept;
   logic              irq_ok;
   logic [ADDR_W-1:0] chk_base [CHK_N];
   logic              chk_ok   [CHK_N];

   eptest_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_W(NUM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .idx_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy),
      .accept_i(accept), .st_set_i(st_set), .csum_i(csum), .cmd_o(cmd),
      .src_o(src), .dst_o(dst), .count_o(count), .itype_o(itype), .inum_o(inum)
   );

   assign chk_base[0] = src;
   assign chk_base[1] = dst;

   generate
      for (genvar g = 0; g < CHK_N; g++) begin : g_chk
         eptest_addr_check #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_chk (
            .base_i(chk_base[g]), .count_i(count), .ok_o(chk_ok[g])
         );
      end
   endgenerate

   eptest_irq_gate #(.NUM_W(NUM_W), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_gate (
      .type_i(itype), .num_i(inum), .ok_o(irq_ok)
   );

   eptest_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_W(NUM_W), .COPY_SUMS(COPY_SUMS)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .src_i(src), .dst_i(dst),
      .count_i(count), .src_ok_i(chk_ok[0]), .dst_ok_i(chk_ok[1]),
      .irq_ok_i(irq_ok), .irq_type_i(itype), .irq_num_i(inum),
      .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .accept_o(accept),
      .busy_o(busy), .st_set_o(st_set), .csum_o(csum), .mem_req_o(mem_req),
      .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .irq_pulse_o(irq_pulse), .irq_kind_o(irq_kind), .irq_num_o(irq_num)
   );
endmodule

// File: rtl/eptest_engine_chk.sv
module eptest_engine_chk #(
   parameter int                ADDR_W    = 32,
   parameter int                NUM_W     = 12,
   parameter int                MSI_MAX   = 32,
   parameter int                MSIX_MAX  = 2048,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 'h1000,
   parameter logic [ADDR_W-1:0] WIN_BYTES = 'h1000
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          mem_req,
   input logic                          mem_we,
   input logic [ADDR_W-1:0]             mem_addr,
   input logic                          mem_ack,
   input logic                          irq_pulse,
   input logic [eptest_pkg::TYPE_W-1:0] irq_kind,
   input logic [NUM_W-1:0]              irq_num
);
   localparam logic [ADDR_W:0]  LO_LIM   = {1'b0, WIN_BASE};
   localparam logic [ADDR_W:0]  HI_LIM   = {1'b0, WIN_BASE} + {1'b0, WIN_BYTES};
   localparam logic [NUM_W-1:0] MSI_LIM  = NUM_W'(MSI_MAX);
   localparam logic [NUM_W-1:0] MSIX_LIM = NUM_W'(MSIX_MAX);

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R6

   AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00); // R7

   AST_MEM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ({1'b0, mem_addr} >= LO_LIM) && ({1'b0, mem_addr} + (ADDR_W+1)'(4) <= HI_LIM)); // R7

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse); // R9

   AST_IRQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (irq_kind == 2'd0 && irq_num == '0)
                 || (irq_kind == 2'd1 && irq_num != '0 && irq_num <= MSI_LIM)
                 || (irq_kind == 2'd2 && irq_num != '0 && irq_num <= MSIX_LIM)); // R8

   AST_NO_REQ_AT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !mem_req); // R10
endmodule

bind eptest_engine eptest_engine_chk #(
   .ADDR_W(ADDR_W), .NUM_W(NUM_W), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX),
   .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
) u_eptest_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_ack(mem_ack), .irq_pulse(irq_pulse),
   .irq_kind(irq_kind), .irq_num(irq_num)
);

// File: tb/eptest_engine_tb.sv
module eptest_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_WORDS  = 1024;
   localparam logic [31:0] WBASE = 32'h1000;

   typedef struct packed {
      logic [5:0]  cmd;
      logic [31:0] src;
      logic [31:0] dst;
      logic [31:0] size;
      logic [1:0]  ityp;
      logic [11:0] inum;
      logic [8:0]  st;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{6'h08, 32'h1000, 32'h0000, 32'd16, 2'd1, 12'd5,    9'h041},
      '{6'h10, 32'h0000, 32'h1800, 32'd12, 2'd0, 12'd0,    9'h044},
      '{6'h20, 32'h1000, 32'h1400, 32'd8,  2'd2, 12'd2048, 9'h050},
      '{6'h08, 32'h1002, 32'h0000, 32'd4,  2'd1, 12'd1,    9'h0C2},
      '{6'h10, 32'h0000, 32'h1800, 32'd0,  2'd1, 12'd3,    9'h148},
      '{6'h20, 32'h1000, 32'h2000, 32'd4,  2'd2, 12'd9,    9'h160},
      '{6'h08, 32'h1FFC, 32'h0000, 32'd4,  2'd1, 12'd32,   9'h041},
      '{6'h08, 32'h1FFC, 32'h0000, 32'd8,  2'd1, 12'd4,    9'h0C2},
      '{6'h20, 32'h0FFC, 32'h1400, 32'd4,  2'd0, 12'd0,    9'h0E0},
      '{6'h08, 32'h1010, 32'h0000, 32'd4,  2'd1, 12'd33,   9'h001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = 4'd2;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        irq_pulse;
   logic [1:0]  irq_kind;
   logic [11:0] irq_num;

   int checks = 0;
   int errors = 0;
   int pulse_cnt = 0;
   int req_cnt = 0;
   logic [1:0]  last_kind = '0;
   logic [11:0] last_num = '0;
   logic [31:0] st_at_pulse = '0;
   logic [31:0] mem [MEM_WORDS];

   eptest_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq_pulse(irq_pulse),
      .irq_kind(irq_kind), .irq_num(irq_num)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int widx(input logic [31:0] a);
      return int'((a - WBASE) >> 2) % MEM_WORDS;
   endfunction

   // host-memory responder: one acknowledge per request, one idle cycle between
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         req_cnt++;
         if (mem_we) mem[widx(mem_addr)] = mem_wdata;
         else        mem_rdata = mem[widx(mem_addr)];
         mem_ack = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (irq_pulse) begin
         pulse_cnt++;
         last_kind   = irq_kind;
         last_num    = irq_num;
         st_at_pulse = reg_rdata;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 4'd2;
   endtask

   task automatic reg_rd(input logic [3:0] idx, output logic [31:0] d);
      @(negedge clk);
      reg_addr = idx;
      #1 d = reg_rdata;
      reg_addr = 4'd2;
   endtask

   task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n,
                        input logic [1:0] t, input logic [11:0] v);
      reg_wr(4'd2, 32'h1FF);
      reg_wr(4'd3, s);
      reg_wr(4'd4, d);
      reg_wr(4'd5, n);
      reg_wr(4'd7, 32'(t));
      reg_wr(4'd8, 32'(v));
   endtask

   task automatic run_vec(input vec_t v);
      logic [31:0] exp_sum, got, old_sum;
      logic [31:0] exp_mem [16];
      int p0, q0, nw;
      string tag;
      bit ok;
      nw = int'(v.size >> 2);
      ok = v.st[0] || v.st[2] || v.st[4];
      tag = !ok ? "R7 refused" : v.cmd[3] ? "R4 read" : v.cmd[4] ? "R5 write" : "R6 copy";
      setup(v.src, v.dst, v.size, v.ityp, v.inum);
      reg_rd(4'd6, old_sum);
      exp_sum = '0;
      for (int k = 0; k < 16; k++) exp_mem[k] = '0;
      if (ok) begin
         for (int k = 0; k < nw; k++) begin
            if (v.cmd[4]) begin
               exp_mem[k] = 32'(k);
               exp_sum += 32'(k);
            end else begin
               exp_mem[k] = mem[widx(v.src + 32'(4*k))];
               exp_sum += exp_mem[k];
            end
         end
      end else begin
         exp_sum = old_sum;
      end
      p0 = pulse_cnt; q0 = req_cnt;
      reg_wr(4'd1, 32'(v.cmd));
      repeat (120) @(negedge clk);
      reg_rd(4'd2, got);
      chk({tag, " status"}, got, 32'(v.st));
      chk({tag, " R9 pulse count"}, 32'(pulse_cnt - p0), v.st[6] ? 32'd1 : 32'd0);
      if (v.st[6]) begin
         chk("R9 kind at pulse", 32'(last_kind), 32'(v.ityp));
         chk("R9 vector at pulse", 32'(last_num), 32'(v.inum));
         chk("R9 status bit 6 in pulse cycle", 32'(st_at_pulse[6]), 32'd1);
      end else begin
         chk("R8 illegal vector gives no pulse", 32'(pulse_cnt - p0), 32'd0);
      end
      reg_rd(4'd6, got);
      chk({tag, " checksum"}, got, exp_sum);
      if (!ok) chk("R7 no memory request", 32'(req_cnt - q0), 32'd0);
      else     chk({tag, " request count"}, 32'(req_cnt - q0),
                   v.cmd[5] ? 32'(2*nw) : 32'(nw));
      if (ok && !v.cmd[3])
         for (int k = 0; k < nw; k++)
            chk({tag, " memory word"}, mem[widx(v.dst + 32'(4*k))], exp_mem[k]);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] got;
      logic [31:0] keep;
      int p0, q0;
      for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0100_0000 + 32'(i) * 32'h0003_0005;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int i = 0; i < 9; i++) begin
         reg_rd(4'(i), got);
         chk("R1 reset value", got, 32'd0);
      end
      chk("R1 no request after reset", 32'(mem_req), 32'd0);
      chk("R9 no pulse after reset", 32'(irq_pulse), 32'd0);
      reg_wr(4'd0, 32'hC0DE_5A17);
      reg_rd(4'd0, got);
      chk("R1 scratch readback", got, 32'hC0DE_5A17);
      reg_wr(4'd0, 32'h0000_FFFF);
      reg_rd(4'd0, got);
      chk("R1 scratch second pattern", got, 32'h0000_FFFF);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R11: write-one-to-clear
      setup(32'h1000, 32'h0, 32'd4, 2'd1, 12'd1);
      reg_wr(4'd1, 32'h08);
      repeat (40) @(negedge clk);
      reg_wr(4'd2, 32'h001);
      reg_rd(4'd2, got);
      chk("R11 clears only written bit", got, 32'h040);
      reg_wr(4'd2, 32'h040);
      reg_rd(4'd2, got);
      chk("R11 status empty", got, 32'h000);

      // R10 and R2: bare interrupt commands, command self-clear
      setup(32'h0, 32'h0, 32'd0, 2'd2, 12'd7);
      p0 = pulse_cnt; q0 = req_cnt;
      reg_wr(4'd1, 32'h02);
      reg_rd(4'd1, got);
      chk("R2 command reads 0 after acceptance", got, 32'd0);
      repeat (5) @(negedge clk);
      chk("R10 one pulse", 32'(pulse_cnt - p0), 32'd1);
      chk("R10 kind from style register", 32'(last_kind), 32'd2);
      chk("R10 vector", 32'(last_num), 32'd7);
      chk("R10 no memory access", 32'(req_cnt - q0), 32'd0);
      reg_rd(4'd2, got);
      chk("R10 status", got, 32'h040);
      setup(32'h0, 32'h0, 32'd0, 2'd1, 12'd32);
      p0 = pulse_cnt;
      reg_wr(4'd1, 32'h04);
      repeat (5) @(negedge clk);
      chk("R10 MSI-X bit pulse", 32'(pulse_cnt - p0), 32'd1);
      chk("R10 MSI top vector", 32'(last_num), 32'd32);

      // R8: legacy with nonzero vector, style 3
      setup(32'h0, 32'h0, 32'd0, 2'd0, 12'd3);
      p0 = pulse_cnt;
      reg_wr(4'd1, 32'h01);
      repeat (5) @(negedge clk);
      chk("R8 legacy nonzero vector no pulse", 32'(pulse_cnt - p0), 32'd0);
      reg_rd(4'd2, got);
      chk("R8 status bit 6 clear", got, 32'h000);
      setup(32'h0, 32'h0, 32'd0, 2'd3, 12'd1);
      reg_wr(4'd1, 32'h01);
      repeat (5) @(negedge clk);
      chk("R8 style 3 no pulse", 32'(pulse_cnt - p0), 32'd0);

      // R3: command written while busy is ignored
      setup(32'h1000, 32'h1C00, 32'd32, 2'd1, 12'd2);
      keep = mem[widx(32'h1C00)];
      p0 = pulse_cnt; q0 = req_cnt;
      reg_wr(4'd1, 32'h08);
      reg_wr(4'd1, 32'h10);
      repeat (10) @(negedge clk);
      reg_wr(4'd1, 32'h10);
      repeat (80) @(negedge clk);
      reg_rd(4'd2, got);
      chk("R3 only the running read completed", got, 32'h041);
      chk("R3 single pulse", 32'(pulse_cnt - p0), 32'd1);
      chk("R3 only read requests", 32'(req_cnt - q0), 32'd8);
      chk("R3 destination untouched", mem[widx(32'h1C00)], keep);
      reg_rd(4'd1, got);
      chk("R3 command register empty", got, 32'd0);

      // R12: lowest set bit wins
      setup(32'h1000, 32'h1C00, 32'd16, 2'd1, 12'd2);
      q0 = req_cnt;
      reg_wr(4'd1, 32'h18);
      repeat (60) @(negedge clk);
      reg_rd(4'd2, got);
      chk("R12 read chosen over write", got, 32'h041);
      chk("R12 read request count", 32'(req_cnt - q0), 32'd4);
      chk("R12 destination untouched", mem[widx(32'h1C00)], keep);

      finish_run();
   end
endmodule